// File: doc/BRIEF.md
# Word/Doubleword I/O Window Decoder

This block sits in front of a small bank of slave I/O resources that occupy a 32-byte window in I/O space. For each access it decides whether the address falls inside the window, and it turns the byte offset into a resource index. It also moves data between the bus byte lanes and the resource. The window's position comes from a programmed base address. Decoding is gated by the I/O-space enable bit of the command register.

The block has two access widths. In word mode every resource is 16 bits wide and sits on a two-byte boundary. In doubleword mode every resource is 32 bits wide and sits on a four-byte boundary. The width is never programmed. The block comes out of hard reset in word mode and learns doubleword mode from traffic: the first full 32-bit write to offset 10h switches it. That write is itself decoded as a doubleword access. After that the block stays in doubleword mode until the next hard reset.

Top module: `io_mode_decoder`

## Requirements
- R1: `hit` is 1 exactly when `io_en` is 1, at least one of `rd`/`wr` is 1, and `addr[31:5]` equals `base[31:5]`. `res_rd` equals `hit & rd` and `res_wr` equals `hit & wr`.
- R2: In word mode, `res_idx` equals `addr[4:1]`.
- R3: In doubleword mode, `res_idx` equals `{1'b0, addr[4:2]}`.
- R4: After hard reset (`rst_n` low), `dw_mode` reads 0, which means word mode.
- R5: A hit write with `be == 4'b1111` and `addr[4:0] == 5'h10` sets `dw_mode` to 1 from the next clock edge.
- R6: The switching write is decoded as a doubleword access in its own cycle: `res_idx` is 4 and `res_wdata` equals `wdata`.
- R7: The mode does not change on any of these: a write to offset 10h with only some byte enables set, a full-width write to another offset, a full-width read of offset 10h, or a full-width write to offset 10h while `io_en` is 0.
- R8: Once `dw_mode` is 1, it stays 1 whatever the traffic, until `rst_n` goes low.
- R9: In word mode, `res_wdata` is the upper half of `wdata` when `addr[1]` is 1 and the lower half otherwise, in bits 15:0, with bits 31:16 zero. In doubleword mode, `res_wdata` equals `wdata`.
- R10: In word mode, `bus_rdata` carries `res_rdata[15:0]` on bits 31:16 when `addr[1]` is 1 and on bits 15:0 otherwise, with the other half zero. In doubleword mode, `bus_rdata` equals `res_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset; returns the block to word mode |
| io_en | input | 1 | I/O space enable from the command register |
| base | input | 32 | Programmed I/O base address (bits 4:0 ignored) |
| addr | input | 32 | Access byte address |
| be | input | 4 | Byte enables, one per lane |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data on the bus lanes |
| res_rdata | input | 32 | Read data from the selected resource, right-aligned |
| hit | output | 1 | Access falls in the enabled window |
| res_rd | output | 1 | Read of the selected resource |
| res_wr | output | 1 | Write of the selected resource |
| res_idx | output | 4 | Resource index |
| res_wdata | output | 32 | Write data aligned to the resource |
| bus_rdata | output | 32 | Read data placed on the bus lanes |
| dw_mode | output | 1 | 1 = doubleword mode, 0 = word mode |

## Verification
The only state in the block is the mode flag, so a wrong flag shows up at the ports in the same cycle as the next access. Every index then doubles or halves, and the data lanes shift by a half-word. The bench therefore probes the index and the lane placement right after every trigger and non-trigger candidate, one clock after the candidate. It also watches `dw_mode` over idle and busy cycles, so that a flag that sets too early, fails to set, or clears is caught at the first following access.

// File: rtl/io_mode_decoder.sv
module io_mode_decoder #(
  parameter int ADDR_W = 32,
  parameter int WIN_LG = 5,
  parameter int DATA_W = 32,
  parameter logic [WIN_LG-1:0] SWITCH_OFF = 5'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_en,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic                rd,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   res_rdata,
  output logic                hit,
  output logic                res_rd,
  output logic                res_wr,
  output logic [WIN_LG-2:0]   res_idx,
  output logic [DATA_W-1:0]   res_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                dw_mode
);
  localparam int HALF = DATA_W / 2;

  logic [WIN_LG-1:0] off;
  logic              trig, dw_eff, hi;
  logic              unused_bits;

  assign off    = addr[WIN_LG-1:0];
  assign hi     = off[1];
  assign hit    = io_en & (rd | wr) & (addr[ADDR_W-1:WIN_LG] == base[ADDR_W-1:WIN_LG]);
  assign res_rd = hit & rd;
  assign res_wr = hit & wr;

  assign trig   = res_wr & (&be) & (off == SWITCH_OFF);
  assign dw_eff = dw_mode | trig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    dw_mode <= 1'b0;
    else if (trig) dw_mode <= 1'b1;

  assign res_idx = dw_eff ? {1'b0, off[WIN_LG-1:2]} : off[WIN_LG-1:1];

  assign res_wdata = dw_eff ? wdata
                   : {{HALF{1'b0}}, (hi ? wdata[DATA_W-1:HALF] : wdata[HALF-1:0])};

  assign bus_rdata = dw_eff ? res_rdata
                   : hi ? {res_rdata[HALF-1:0], {HALF{1'b0}}}
                        : {{HALF{1'b0}}, res_rdata[HALF-1:0]};

  assign unused_bits = ^{off[0], base[WIN_LG-1:0]};

  AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (io_en && (rd || wr)));                                    // R1
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dw_mode |=> dw_mode);                                              // R8
  AST_MODE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dw_mode) |-> $past(hit && wr && (&be) && addr[WIN_LG-1:0] == SWITCH_OFF)); // R5
  AST_DW_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dw_mode |-> !res_idx[WIN_LG-2]);                                   // R3
  AST_DW_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    dw_mode |-> res_wdata == wdata);                                   // R9
endmodule

// File: tb/sim_io_mode_decoder.sv
module sim_io_mode_decoder;
  logic clk = 0, rst_n = 0, io_en = 0, rd = 0, wr = 0;
  logic [31:0] base = 32'h0000_C300, addr = 0, wdata = 0, res_rdata = 0;
  logic [3:0] be = 0;
  logic hit, res_rd, res_wr, dw_mode;
  logic [3:0] res_idx;
  logic [31:0] res_wdata, bus_rdata;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  io_mode_decoder u0 (.clk(clk), .rst_n(rst_n), .io_en(io_en), .base(base), .addr(addr),
    .be(be), .rd(rd), .wr(wr), .wdata(wdata), .res_rdata(res_rdata), .hit(hit),
    .res_rd(res_rd), .res_wr(res_wr), .res_idx(res_idx), .res_wdata(res_wdata),
    .bus_rdata(bus_rdata), .dw_mode(dw_mode));

  // {en, rd, wr, be[3:0], off[4:0], in_window, exp_hit, exp_idx[3:0]}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,4'h3,5'h00,1'b1,1'b1,4'd0},
    {1'b1,1'b0,1'b1,4'hC,5'h06,1'b1,1'b1,4'd3},
    {1'b1,1'b1,1'b0,4'h3,5'h1E,1'b1,1'b1,4'd15},
    {1'b1,1'b0,1'b1,4'h3,5'h12,1'b1,1'b1,4'd9},
    {1'b0,1'b1,1'b0,4'h3,5'h04,1'b1,1'b0,4'd2},
    {1'b1,1'b1,1'b0,4'h3,5'h04,1'b0,1'b0,4'd2},
    {1'b1,1'b0,1'b0,4'h3,5'h08,1'b1,1'b0,4'd4},
    {1'b1,1'b0,1'b1,4'h3,5'h1A,1'b0,1'b0,4'd13}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic en, input logic r, input logic w, input logic [3:0] b,
                       input logic [4:0] off, input logic inwin);
    @(negedge clk);
    io_en = en; rd = r; wr = w; be = b;
    addr = (inwin ? base : base + 32'h20) | {27'd0, off};
    #1;
  endtask

  task automatic idle();
    @(negedge clk); rd = 0; wr = 0; io_en = 1; #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R4 reset mode", {31'd0, dw_mode}, 32'd0);
    chk("R1 idle no hit", {31'd0, hit}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14:11], VEC[i][10:6], VEC[i][5]);
      chk($sformatf("R1 hit vec%0d", i), {31'd0, hit}, {31'd0, VEC[i][4]});
      chk($sformatf("R1 strobes vec%0d", i), {30'd0, res_rd, res_wr},
          {30'd0, VEC[i][4] & VEC[i][16], VEC[i][4] & VEC[i][15]});
      if (VEC[i][4]) chk($sformatf("R2 idx vec%0d", i), {28'd0, res_idx}, {28'd0, VEC[i][3:0]});
    end

    wdata = 32'hAAAA_5555; res_rdata = 32'h1234_ABCD;
    drive(1, 0, 1, 4'hC, 5'h12, 1);
    chk("R9 word upper lane", res_wdata, 32'h0000_AAAA);
    drive(1, 0, 1, 4'h3, 5'h10, 1);
    chk("R9 word lower lane", res_wdata, 32'h0000_5555);
    chk("R2 idx 10h word", {28'd0, res_idx}, 32'd8);
    idle();
    chk("R7 half write at 10h", {31'd0, dw_mode}, 32'd0);
    drive(1, 1, 0, 4'h3, 5'h16, 1);
    chk("R10 word read upper", bus_rdata, 32'hABCD_0000);
    drive(1, 1, 0, 4'h3, 5'h14, 1);
    chk("R10 word read lower", bus_rdata, 32'h0000_ABCD);
    drive(1, 0, 1, 4'hF, 5'h14, 1); idle();
    chk("R7 full write elsewhere", {31'd0, dw_mode}, 32'd0);
    drive(1, 1, 0, 4'hF, 5'h10, 1); idle();
    chk("R7 full read at 10h", {31'd0, dw_mode}, 32'd0);
    drive(0, 0, 1, 4'hF, 5'h10, 1); idle();
    chk("R7 disabled trigger", {31'd0, dw_mode}, 32'd0);
    drive(1, 0, 1, 4'hF, 5'h10, 0); idle();
    chk("R7 trigger outside window", {31'd0, dw_mode}, 32'd0);

    drive(1, 0, 1, 4'hF, 5'h10, 1);
    chk("R6 trigger idx", {28'd0, res_idx}, 32'd4);
    chk("R6 trigger data", res_wdata, 32'hAAAA_5555);
    chk("R5 not yet set", {31'd0, dw_mode}, 32'd0);
    idle();
    chk("R5 mode set", {31'd0, dw_mode}, 32'd1);

    drive(1, 1, 0, 4'hF, 5'h1C, 1);
    chk("R3 idx 1Ch", {28'd0, res_idx}, 32'd7);
    chk("R10 dw read", bus_rdata, 32'h1234_ABCD);
    drive(1, 0, 1, 4'hF, 5'h0C, 1);
    chk("R3 idx 0Ch", {28'd0, res_idx}, 32'd3);
    chk("R9 dw write", res_wdata, 32'hAAAA_5555);
    drive(1, 0, 1, 4'h3, 5'h02, 1);
    chk("R3 idx 02h", {28'd0, res_idx}, 32'd0);
    drive(0, 1, 0, 4'h3, 5'h10, 1);
    repeat (5) idle();
    chk("R8 sticky", {31'd0, dw_mode}, 32'd1);

    @(negedge clk); rst_n = 0; #1;
    chk("R4 hard reset clears", {31'd0, dw_mode}, 32'd0);
    @(negedge clk); rst_n = 1;
    drive(1, 1, 0, 4'h3, 5'h1C, 1);
    chk("R2 idx after reset", {28'd0, res_idx}, 32'd14);
    finish_run();
  end
endmodule